// File: doc/BRIEF.md
# Transparent TDM Channel Transmitter

This block moves bytes from a transmit FIFO onto chosen time slots of a frame-based serial bus. It sends them as raw data. It generates no opening or closing flags, computes no checksum and inserts no stuffing bits. The processor issues a transmit command, optionally with an end-of-message mark. The block then waits for the next frame start and begins shifting bytes out, MSB first, one bit in each bit-clock cycle that falls inside an enabled slot.

Three slot channels exist: two 8-bit data slots and one 2-bit signalling slot. A per-channel select chooses which of them carry the message. When only the 2-bit slot is used, a byte is spread over four frames. The block reports its result with a single-cycle interrupt pulse:
- "ready" when a marked message ends normally;
- "repeat" when a stop indication arrives while collision handling is enabled;
- "underrun" when the FIFO runs dry before the end mark.

Outside the active mode, and whenever it has nothing to send, the line is held at logic 1.

Top module: `tdm_xparent_tx`

## Requirements
- R1: The block works only while `mode_i` equals binary 100. With any other value the state falls back to idle, commands have no effect, `tx_o` is 1 from the next cycle, and no interrupt is pulsed.
- R2: Each FIFO byte is sent unmodified, MSB first. One bit goes out per cycle in which a selected slot strobe is high. The strobe and select vectors use bit 0 for the first 8-bit slot, bit 1 for the second 8-bit slot and bit 2 for the 2-bit slot. `tx_o` shows the bit during that same cycle.
- R3: `fifo_rd_o` is high for one cycle each time a byte is taken: at the frame start that opens the message, and in the last bit cycle of each byte when the FIFO is not empty. It is never high while `fifo_empty_i` is high.
- R4: After a transmit command, output begins at the first selected slot bit after the next `frame_sync_i`, never in the current frame. A transmit command given while a message is pending or running is ignored.
- R5: While idle or waiting for the frame start, `tx_o` is 1. After reset, `tx_o` is 1 and all interrupts are 0.
- R6: If the end mark has been given (with the command or later) and the FIFO is empty when the last bit of a byte is sent, `int_ready_o` pulses in the next cycle and the block returns to idle.
- R7: With `coll_en_i` at 1, a `stop_i` of 1 in any cycle of an active transmission pulses `int_repeat_o` in the next cycle and aborts the message. With `coll_en_i` at 0, `stop_i` has no effect.
- R8: `int_underrun_o` pulses in the next cycle, and the message is aborted, when the FIFO is empty either at the opening frame start or at a byte end without the end mark.
- R9: Each interrupt lasts exactly one cycle, and at most one interrupt is high in any cycle.
- R10: When only the 2-bit slot is selected, a byte continues across frames, two bits per frame, and arrives intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode; 100 enables the block |
| frame_sync_i | input | 1 | One-cycle frame start marker |
| slot_strb_i | input | 3 | Per-channel strobe, high during each bit of that slot |
| chan_sel_i | input | 3 | Per-channel select for carrying the message |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO (show-ahead) |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_rd_o | output | 1 | Pop the head byte |
| cmd_xmit_i | input | 1 | Transmit command pulse |
| cmd_eom_i | input | 1 | End-of-message mark pulse |
| coll_en_i | input | 1 | Collision handling enable |
| stop_i | input | 1 | Stop indication (1 = stop) |
| tx_o | output | 1 | Serial data out |
| int_ready_o | output | 1 | Message done, ready for more |
| int_repeat_o | output | 1 | Message aborted by stop, repeat needed |
| int_underrun_o | output | 1 | FIFO ran dry mid-message |

## Verification
Random messages of one to four bytes are sent under random channel selections, from single-slot to all three. This separates correct bit counting per slot from a design that assumes fixed 8-bit slots. Some messages carry the end mark and some do not, which tells the normal ending apart from the underrun path. Stop pulses are injected at random times with collision handling both on and off, to show that the stop input is honoured only when enabled. Directed cases cover commands given in a wrong mode, a command right at a frame start (the start must be deferred a full frame), an empty FIFO at the opening frame, and a 2-bit-slot-only message whose bytes must be reassembled across frames.

// File: rtl/tdm_xparent_pkg.sv
package tdm_xparent_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;

    typedef struct packed {
        tx_state_e st;
        logic      eom;
        logic      irq_ready;
        logic      irq_repeat;
        logic      irq_under;
    } ctrl_s;

endpackage

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] slot_strb_i,
    input  logic [NUM_CH-1:0] chan_sel_i,
    output logic              bit_cyc_o
);

    logic [NUM_CH-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            assign hit[g] = slot_strb_i[g] & chan_sel_i[g];
        end
    endgenerate

    assign bit_cyc_o = |hit;

endmodule

// File: rtl/tdm_byte_shreg.sv
module tdm_byte_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic         msb_o,
    output logic         last_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } sr_s;

    sr_s sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d.sh  = din_i;
            sr_d.cnt = '0;
        end else if (shift_i) begin
            sr_d.sh  = {sr_q.sh[W-2:0], 1'b0};
            sr_d.cnt = sr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb_o  = sr_q.sh[W-1];
    assign last_o = (sr_q.cnt == CW'(W-1));

endmodule

// File: rtl/tdm_tx_fsm.sv
module tdm_tx_fsm
    import tdm_xparent_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ok_i,
    input  logic frame_sync_i,
    input  logic bit_cyc_i,
    input  logic last_bit_i,
    input  logic fifo_empty_i,
    input  logic cmd_xmit_i,
    input  logic cmd_eom_i,
    input  logic coll_en_i,
    input  logic stop_i,
    output logic load_o,
    output logic shift_o,
    output logic sending_o,
    output logic irq_ready_o,
    output logic irq_repeat_o,
    output logic irq_under_o
);

    ctrl_s c_d, c_q;

    always_comb begin
        c_d            = c_q;
        c_d.irq_ready  = 1'b0;
        c_d.irq_repeat = 1'b0;
        c_d.irq_under  = 1'b0;
        load_o         = 1'b0;
        if (!mode_ok_i) begin
            c_d.st  = ST_IDLE;
            c_d.eom = 1'b0;
        end else begin
            case (c_q.st)
                ST_IDLE: begin
                    if (cmd_xmit_i) begin
                        c_d.st  = ST_ARMED;
                        c_d.eom = cmd_eom_i;
                    end
                end
                ST_ARMED: begin
                    c_d.eom = c_q.eom | cmd_eom_i;
                    if (frame_sync_i) begin
                        if (!fifo_empty_i) begin
                            load_o = 1'b1;
                            c_d.st = ST_SEND;
                        end else begin
                            c_d.irq_under = 1'b1;
                            c_d.st        = ST_IDLE;
                        end
                    end
                end
                ST_SEND: begin
                    c_d.eom = c_q.eom | cmd_eom_i;
                    if (coll_en_i && stop_i) begin
                        c_d.irq_repeat = 1'b1;
                        c_d.st         = ST_IDLE;
                    end else if (bit_cyc_i && last_bit_i) begin
                        if (!fifo_empty_i) begin
                            load_o = 1'b1;
                        end else if (c_d.eom) begin
                            c_d.irq_ready = 1'b1;
                            c_d.st        = ST_IDLE;
                        end else begin
                            c_d.irq_under = 1'b1;
                            c_d.st        = ST_IDLE;
                        end
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: 1'b0};
        else        c_q <= c_d;
    end

    assign sending_o    = (c_q.st == ST_SEND);
    assign shift_o      = sending_o & bit_cyc_i;
    assign irq_ready_o  = c_q.irq_ready;
    assign irq_repeat_o = c_q.irq_repeat;
    assign irq_under_o  = c_q.irq_under;

endmodule

// File: rtl/tdm_xparent_tx.sv
module tdm_xparent_tx #(
    parameter int              BYTE_W  = 8,
    parameter int              NUM_CH  = 3,
    parameter int              MODE_W  = 3,
    parameter logic [MODE_W-1:0] MODE_ON = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              frame_sync_i,
    input  logic [NUM_CH-1:0] slot_strb_i,
    input  logic [NUM_CH-1:0] chan_sel_i,
    input  logic [BYTE_W-1:0] fifo_data_i,
    input  logic              fifo_empty_i,
    output logic              fifo_rd_o,
    input  logic              cmd_xmit_i,
    input  logic              cmd_eom_i,
    input  logic              coll_en_i,
    input  logic              stop_i,
    output logic              tx_o,
    output logic              int_ready_o,
    output logic              int_repeat_o,
    output logic              int_underrun_o
);

    logic mode_ok;
    logic bit_cyc;
    logic load, shift, sending;
    logic msb, last_bit;

    assign mode_ok = (mode_i == MODE_ON);

    tdm_slot_gate #(.NUM_CH(NUM_CH)) u_gate (
        .slot_strb_i (slot_strb_i),
        .chan_sel_i  (chan_sel_i),
        .bit_cyc_o   (bit_cyc)
    );

    tdm_byte_shreg #(.W(BYTE_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .din_i   (fifo_data_i),
        .msb_o   (msb),
        .last_o  (last_bit)
    );

    tdm_tx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_ok_i    (mode_ok),
        .frame_sync_i (frame_sync_i),
        .bit_cyc_i    (bit_cyc),
        .last_bit_i   (last_bit),
        .fifo_empty_i (fifo_empty_i),
        .cmd_xmit_i   (cmd_xmit_i),
        .cmd_eom_i    (cmd_eom_i),
        .coll_en_i    (coll_en_i),
        .stop_i       (stop_i),
        .load_o       (load),
        .shift_o      (shift),
        .sending_o    (sending),
        .irq_ready_o  (int_ready_o),
        .irq_repeat_o (int_repeat_o),
        .irq_under_o  (int_underrun_o)
    );

    assign fifo_rd_o = load;
    assign tx_o      = sending ? msb : 1'b1;

endmodule

// File: rtl/tdm_xparent_tx_chk.sv
module tdm_xparent_tx_chk #(
    parameter int              MODE_W  = 3,
    parameter logic [MODE_W-1:0] MODE_ON = 3'b100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              frame_sync_i,
    input logic              fifo_empty_i,
    input logic              fifo_rd_o,
    input logic              coll_en_i,
    input logic              stop_i,
    input logic              sending,
    input logic              tx_o,
    input logic              int_ready_o,
    input logic              int_repeat_o,
    input logic              int_underrun_o
);

    // R1
    mode_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_ON) |=> (tx_o && !int_ready_o && !int_repeat_o && !int_underrun_o));

    // R3
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    // R4
    start_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sending) |-> $past(frame_sync_i));

    // R5
    line_high_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ready_o || int_repeat_o || int_underrun_o) |-> tx_o);

    // R7
    stop_gives_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && coll_en_i && stop_i && mode_i == MODE_ON) |=> int_repeat_o);

    // R9
    single_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({int_ready_o, int_repeat_o, int_underrun_o}) <= 1);

    // R9
    ready_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ready_o |=> !int_ready_o);

    // R9
    under_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_underrun_o |=> !int_underrun_o);

endmodule

bind tdm_xparent_tx tdm_xparent_tx_chk #(.MODE_W(MODE_W), .MODE_ON(MODE_ON)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .frame_sync_i   (frame_sync_i),
    .fifo_empty_i   (fifo_empty_i),
    .fifo_rd_o      (fifo_rd_o),
    .coll_en_i      (coll_en_i),
    .stop_i         (stop_i),
    .sending        (sending),
    .tx_o           (tx_o),
    .int_ready_o    (int_ready_o),
    .int_repeat_o   (int_repeat_o),
    .int_underrun_o (int_underrun_o)
);

// File: tb/tdm_xparent_tx_tb.sv
module tdm_xparent_tx_tb;

    localparam int FRAME_LEN = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b100;
    logic       fs = 1'b0;
    logic [2:0] strb = '0;
    logic [2:0] sel = '0;
    logic [7:0] fdata = '0;
    logic       fempty = 1'b1;
    logic       rd;
    logic       xmit = 1'b0, eom = 1'b0, coll = 1'b0, stop = 1'b0;
    logic       tx, ir, irep, iund;

    always #2 clk = ~clk;

    tdm_xparent_tx u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .frame_sync_i(fs),
        .slot_strb_i(strb), .chan_sel_i(sel), .fifo_data_i(fdata),
        .fifo_empty_i(fempty), .fifo_rd_o(rd), .cmd_xmit_i(xmit),
        .cmd_eom_i(eom), .coll_en_i(coll), .stop_i(stop), .tx_o(tx),
        .int_ready_o(ir), .int_repeat_o(irep), .int_underrun_o(iund)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // scenario controls
    logic [2:0] s_mode = 3'b100;
    logic [2:0] s_sel  = 3'b001;
    logic       s_coll = 1'b0;
    logic       s_stop = 1'b0;
    logic       c_x = 1'b0, c_e = 1'b0;
    int         pos = 1;
    logic [7:0] fifo_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] rx_sh;
    int         rx_n;

    // reference model state: 0 idle, 1 armed, 2 send
    int         m_st = 0;
    logic [7:0] m_sh = '0;
    int         m_cnt = 0;
    logic       m_eom = 1'b0;
    logic       e_ready = 0, e_rep = 0, e_und = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] strobe_at(input int p);
        if (p >= 1 && p <= 8)   return 3'b001;
        if (p >= 9 && p <= 16)  return 3'b010;
        if (p >= 17 && p <= 18) return 3'b100;
        return 3'b000;
    endfunction

    task automatic tick();
        logic       bitc, mok, exp_tx, exp_rd, eom_now;
        logic       n_ready, n_rep, n_und;
        string      lbl;
        @(negedge clk);
        check(ir == e_ready, "R6", ir, e_ready);
        check(irep == e_rep, "R7", irep, e_rep);
        check(iund == e_und, "R8", iund, e_und);
        check((32'(ir) + 32'(irep) + 32'(iund)) <= 1, "R9", ir + irep + iund, 1);
        mode = s_mode; sel = s_sel; coll = s_coll; stop = s_stop;
        xmit = c_x; eom = c_e;
        fs = (pos == 0);
        strb = strobe_at(pos);
        fempty = (fifo_q.size() == 0);
        fdata = fempty ? 8'h00 : fifo_q[0];
        #1;
        mok  = (mode == 3'b100);
        bitc = |(strb & sel);
        exp_tx = (m_st == 2) ? m_sh[7] : 1'b1;
        lbl = (m_st == 2) ? (sel == 3'b100 ? "R10" : "R2") :
              (!mok ? "R1" : (m_st == 1 ? "R4" : "R5"));
        check(tx == exp_tx, lbl, tx, exp_tx);
        if (m_st == 2 && bitc) begin
            rx_sh = {rx_sh[6:0], tx};
            rx_n++;
            if (rx_n == 8) begin rx_q.push_back(rx_sh); rx_n = 0; end
        end
        exp_rd = 0; n_ready = 0; n_rep = 0; n_und = 0;
        if (!mok) begin
            m_st = 0; m_eom = 0;
        end else if (m_st == 0) begin
            if (xmit) begin m_st = 1; m_eom = eom; end
        end else if (m_st == 1) begin
            m_eom = m_eom | eom;
            if (fs) begin
                if (!fempty) begin exp_rd = 1; m_sh = fdata; m_cnt = 0; m_st = 2; end
                else begin n_und = 1; m_st = 0; end
            end
        end else begin
            eom_now = m_eom | eom;
            m_eom = eom_now;
            if (coll && stop) begin
                n_rep = 1; m_st = 0;
            end else if (bitc) begin
                if (m_cnt == 7) begin
                    if (!fempty) begin exp_rd = 1; m_sh = fdata; m_cnt = 0; end
                    else if (eom_now) begin n_ready = 1; m_st = 0; end
                    else begin n_und = 1; m_st = 0; end
                end else begin
                    m_sh = {m_sh[6:0], 1'b0};
                    m_cnt++;
                end
            end
        end
        check(rd == exp_rd, "R3", rd, exp_rd);
        if (exp_rd && fifo_q.size() > 0) void'(fifo_q.pop_front());
        e_ready = n_ready; e_rep = n_rep; e_und = n_und;
        pos = (pos + 1) % FRAME_LEN;
        c_x = 0; c_e = 0; s_stop = 0;
    endtask

    // send one message; stop_at < 0 means no stop
    task automatic run_msg(input int nbytes, input logic [2:0] selv, input bit with_eom,
                           input int prefill, input int stop_at, input bit collv,
                           input string req);
        logic [7:0] sent[$];
        int pushed = 0;
        int cyc = 0;
        bit clean;
        logic [7:0] b;
        fifo_q.delete(); rx_q.delete(); rx_n = 0;
        s_sel = selv; s_coll = collv;
        for (int i = 0; i < prefill && i < nbytes; i++) begin
            b = 8'($urandom); fifo_q.push_back(b); sent.push_back(b); pushed++;
        end
        c_x = 1; c_e = with_eom;
        tick();
        clean = (stop_at < 0 || !collv) && (prefill >= nbytes || prefill > 0);
        while (m_st != 0 && cyc < 2000) begin
            if (prefill >= nbytes && pushed < nbytes && fifo_q.size() < 2) begin
                b = 8'($urandom); fifo_q.push_back(b); sent.push_back(b); pushed++;
            end
            if (cyc == stop_at) s_stop = 1;
            tick();
            cyc++;
        end
        if (clean && prefill >= nbytes) begin
            check(rx_q.size() == nbytes, req, rx_q.size(), nbytes);
            for (int i = 0; i < nbytes && i < rx_q.size(); i++)
                check(rx_q[i] == sent[i], req, rx_q[i], sent[i]);
        end
        for (int i = 0; i < 5; i++) tick();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R5: reset state
        check(tx == 1'b1, "R5", tx, 1);
        check({ir, irep, iund} == 3'b000, "R5", {ir, irep, iund}, 0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 25; i++) tick();

        // R1: commands in a wrong mode are ignored
        s_mode = 3'b000;
        fifo_q.push_back(8'h0F);
        c_x = 1; c_e = 1;
        for (int i = 0; i < 70; i++) tick();
        check(fifo_q.size() == 1, "R1", fifo_q.size(), 1);
        s_mode = 3'b100;
        fifo_q.delete();
        for (int i = 0; i < 5; i++) tick();

        // R4: command issued at the frame-start cycle waits a full frame
        while (pos != 0) tick();
        run_msg(2, 3'b011, 1, 2, -1, 0, "R4");
        // R2: all three slots, end mark
        run_msg(3, 3'b111, 1, 3, -1, 0, "R2");
        // R10: 2-bit slot only, byte spans frames
        run_msg(2, 3'b100, 1, 2, -1, 0, "R10");
        // R8: empty FIFO at opening frame
        run_msg(1, 3'b001, 0, 0, -1, 0, "R8");
        // R8: no end mark, FIFO runs dry
        run_msg(2, 3'b001, 0, 2, -1, 0, "R8");
        // R7: stop with collision handling on
        run_msg(3, 3'b011, 1, 3, 40, 1, "R7");
        // R7: stop ignored with collision handling off
        run_msg(2, 3'b001, 1, 2, 30, 0, "R7");
        // R1: mode dropped mid-message
        fifo_q.push_back(8'hA5); fifo_q.push_back(8'h3C);
        s_sel = 3'b001; c_x = 1; c_e = 1;
        for (int i = 0; i < 30; i++) tick();
        s_mode = 3'b101;
        for (int i = 0; i < 30; i++) tick();
        s_mode = 3'b100;
        for (int i = 0; i < 5; i++) tick();

        // random messages
        for (int k = 0; k < 40; k++) begin
            int nb;
            logic [2:0] sv;
            bit em, cl;
            int sa;
            nb = 1 + int'($urandom % 4);
            sv = 3'(1 + ($urandom % 7));
            em = ($urandom % 3) != 0;
            cl = $urandom % 2;
            sa = ($urandom % 4 == 0) ? int'($urandom % 200) : -1;
            for (int j = 0; j < int'($urandom % 25); j++) tick();
            run_msg(nb, sv, em, nb, sa, cl, "R2");
        end

        for (int i = 0; i < 5; i++) tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule